// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of peripheral interrupt sources and a small processor core. It gathers the requests and presents the core with a single request line and the vector address of the most urgent request. Each source is set up at elaboration time as one of two kinds. An event source latches a pending flag on a rising edge of its input. A level source requests only while its input is high and never latches anything.

Software reaches the controller through a small register port. The port holds a per-source enable mask, the pending flags (cleared by writing ones), a global enable bit, and a read-only view of the enabled requests. When the core takes an interrupt, it pulses an acknowledge in the same cycle in which it samples the vector. The controller then drops the global enable and clears the latched flag of the source it reported. A separate return strobe sets the global enable again, so events that were held back are served one at a time in priority order.

Top module: `pvic`

## Requirements
- R1: After reset the enable mask, all pending flags and the global enable read zero, `irq_o` is low and `vec_o` is zero.
- R2: A rising edge on an event source's input sets its pending flag even when that source is masked or the global enable is clear. The flag then stays set until it is cleared by software or by an acknowledge.
- R3: Writing register 1 clears each flag whose data bit is one and leaves the flags whose bit is zero unchanged. If a new event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: A level source requests only while its input is high. Its flag bit always reads zero. A level input that goes away before the source is enabled leaves no request behind.
- R5: `irq_o` is high exactly when the global enable is set and at least one enabled source is pending. `vec_o` equals VEC_BASE + (i+1)*VEC_STEP for the reported source bit i, where index 0 is kept for reset. `vec_o` is zero while `irq_o` is low.
- R6: When several enabled sources are pending at once, the one with the lowest bit index (lowest vector) is reported.
- R7: An `ack_i` while `irq_o` is high clears the global enable and, for an event source, the flag of the reported source. The other flags are untouched. An `ack_i` while `irq_o` is low has no effect.
- R8: A `reti_i` pulse sets the global enable. An accepted acknowledge in the same cycle wins over it, and both win over a software write of the global enable in that cycle.
- R9: Register map by `wr_addr`/`rd_addr`. Address 0 is the enable mask (read/write). Address 1 is the pending flags (read, write-one-to-clear). Address 2 holds the global enable in bit 0 (read/write, upper bits read zero). Address 3 reads the enabled requests without regard to the global enable, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Interrupt source inputs, bit i is vector index i+1 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | NSRC | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | NSRC | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | VEC_W | Vector address of the reported source |
| ack_i | input | 1 | Core takes the reported vector this cycle |
| reti_i | input | 1 | Return from interrupt, restores the global enable |

## Verification
The bench builds the controller with six sources. Bits 2 and 5 are level sources, the vector base is 0x100 and the spacing is 2. With that mix, latched and non-latched sources compete in the same priority chain, and a level source can lose to an event source below it and beat one above it. The directed sequences cover masked events that fire once enabled, simultaneous events resolved by index, set-over-clear collisions, ack together with return, and level inputs that vanish before enabling. A long randomized run with a fixed seed is then checked cycle by cycle against a bench model of the registers.

// File: rtl/pvic.sv
module pvic #(
  parameter int              NSRC      = 6,
  parameter logic [NSRC-1:0] LEVEL_SRC = '0,
  parameter int              VEC_W     = 16,
  parameter int              VEC_BASE  = 0,
  parameter int              VEC_STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [NSRC-1:0]  wr_data,
  input  logic [1:0]       rd_addr,
  output logic [NSRC-1:0]  rd_data,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  input  logic             ack_i,
  input  logic             reti_i
);

  localparam int              IDX_W   = $clog2(NSRC + 1);
  localparam logic [NSRC-1:0] EVT_SRC = ~LEVEL_SRC;

  logic [NSRC-1:0]  en_q, flag_q, src_q;
  logic             gie_q;
  logic [NSRC-1:0]  set_evt, pend, req, win_oh, hw_clr, sw_clr;
  logic [IDX_W-1:0] win_num;
  logic             taken, flag_wr;

  assign set_evt = src_i & ~src_q & EVT_SRC;
  assign pend    = flag_q | (src_i & LEVEL_SRC);
  assign req     = pend & en_q;
  assign win_oh  = req & (~req + NSRC'(1));
  assign irq_o   = gie_q & (|req);
  assign taken   = ack_i & irq_o;
  assign flag_wr = wr_en && (wr_addr == 2'd1);
  assign hw_clr  = taken ? (win_oh & EVT_SRC) : '0;
  assign sw_clr  = flag_wr ? wr_data : '0;

  always_comb begin
    win_num = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (req[i]) win_num = IDX_W'(i + 1);
  end

  assign vec_o = irq_o ? (VEC_W'(VEC_BASE) + VEC_W'(win_num) * VEC_W'(VEC_STEP)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
      src_q  <= '0;
      gie_q  <= 1'b0;
    end else begin
      src_q  <= src_i;
      flag_q <= ((flag_q & ~sw_clr & ~hw_clr) | set_evt) & EVT_SRC;
      if (wr_en && wr_addr == 2'd0) en_q <= wr_data;
      if (taken)                              gie_q <= 1'b0;
      else if (reti_i)                        gie_q <= 1'b1;
      else if (wr_en && wr_addr == 2'd2)      gie_q <= wr_data[0];
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = en_q;
      2'd1:    rd_data = flag_q;
      2'd2:    rd_data = NSRC'(gie_q);
      default: rd_data = req;
    endcase
  end

  AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flag_q & $past(set_evt)) == $past(set_evt)));  // R2

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr && !taken) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));  // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_wr |=> ((flag_q & $past(wr_data & ~set_evt)) == '0));  // R3

  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> !gie_q);  // R7

  AST_ACK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> ((flag_q & $past(win_oh & ~set_evt)) == '0));  // R7

  AST_RETI_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !taken) |=> gie_q);  // R8

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));  // R6

endmodule

// File: tb/test_pvic.sv
module test_pvic;
  localparam int N = 6;
  localparam logic [N-1:0] LVL = 6'b100100;
  localparam int BASE = 'h100;
  localparam int STEP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0, wd = '0;
  logic we = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [1:0] wa = '0, ra = '0;
  logic [N-1:0] rd;
  logic irq;
  logic [15:0] vec;

  always #10 clk = ~clk;

  pvic #(.NSRC(N), .LEVEL_SRC(LVL), .VEC_W(16), .VEC_BASE(BASE), .VEC_STEP(STEP)) i_pvic (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_addr(ra), .rd_data(rd), .irq_o(irq), .vec_o(vec), .ack_i(ack), .reti_i(reti));

  int total = 0, fails = 0;
  bit done = 0;
  logic [N-1:0] m_en = '0, m_flag = '0, m_prev = '0, cur_s = '0;
  logic m_gie = 1'b0;
  logic o_irq;
  logic [15:0] o_vec;
  logic [N-1:0] o_rd;

  function automatic logic [N-1:0] f_req(input logic [N-1:0] s);
    return ((m_flag & ~LVL) | (s & LVL)) & m_en;
  endfunction
  function automatic logic f_irq(input logic [N-1:0] s);
    return m_gie && (|f_req(s));
  endfunction
  function automatic logic [15:0] f_vec(input logic [N-1:0] s);
    logic [N-1:0] r = f_req(s);
    if (!f_irq(s)) return 16'h0;
    for (int i = 0; i < N; i++) if (r[i]) return 16'(BASE + (i + 1) * STEP);
    return 16'h0;
  endfunction
  function automatic logic [N-1:0] f_rd(input logic [N-1:0] s, input logic [1:0] a);
    case (a)
      2'd0: return m_en;
      2'd1: return m_flag;
      2'd2: return N'(m_gie);
      default: return f_req(s);
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] s, input logic w, input logic [1:0] a,
                      input logic [N-1:0] d, input logic k, input logic r, input logic [1:0] rda);
    logic taken;
    logic [N-1:0] clr, wins;
    @(negedge clk);
    src = s; we = w; wa = a; wd = d; ack = k; reti = r; ra = rda; cur_s = s;
    #1;
    o_irq = irq; o_vec = vec; o_rd = rd;
    chk("R5 irq vs model", int'(irq), int'(f_irq(s)));
    chk("R5 vec vs model", int'(vec), int'(f_vec(s)));
    chk("R9 rd vs model", int'(rd), int'(f_rd(s, rda)));
    taken = k && f_irq(s);
    wins = f_req(s) & (~f_req(s) + N'(1));
    clr = taken ? (wins & ~LVL) : '0;
    @(posedge clk);
    m_flag = ((m_flag & ~((w && a == 2'd1) ? d : '0) & ~clr) | (s & ~m_prev & ~LVL)) & ~LVL;
    if (w && a == 2'd0) m_en = d;
    if (taken) m_gie = 1'b0;
    else if (r) m_gie = 1'b1;
    else if (w && a == 2'd2) m_gie = d[0];
    m_prev = s;
  endtask

  task automatic idle(input logic [1:0] rda);
    step(cur_s, 1'b0, 2'd0, '0, 1'b0, 1'b0, rda);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    step(cur_s, 1'b1, a, d, 1'b0, 1'b0, 2'd0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    idle(2'd0); chk("R1 enable reset", int'(o_rd), 0);
    chk("R1 irq reset", int'(o_irq), 0); chk("R1 vec reset", int'(o_vec), 0);
    idle(2'd1); chk("R1 flags reset", int'(o_rd), 0);
    idle(2'd2); chk("R1 gie reset", int'(o_rd), 0);

    wr(2'd2, 6'h01);
    step(6'b000010, 1'b0, 2'd0, '0, 1'b0, 1'b0, 2'd0);
    idle(2'd1); chk("R2 masked event latched", int'(o_rd), 'h02);
    chk("R2 masked no irq", int'(o_irq), 0);
    wr(2'd0, 6'h3F);
    idle(2'd0); chk("R2 pending fires once enabled", int'(o_irq), 1);
    chk("R5 vector of source bit1", int'(o_vec), 'h104);

    step(6'b000000, 1'b1, 2'd1, 6'h02, 1'b0, 1'b0, 2'd0);
    step(6'b010010, 1'b0, 2'd0, '0, 1'b0, 1'b0, 2'd0);
    idle(2'd1); chk("R6 two events latched", int'(o_rd), 'h12);
    chk("R6 lowest index wins", int'(o_vec), 'h104);
    step(cur_s, 1'b0, 2'd0, '0, 1'b1, 1'b0, 2'd1);
    idle(2'd1); chk("R7 ack clears reported flag only", int'(o_rd), 'h10);
    chk("R7 ack drops irq", int'(o_irq), 0);
    step(cur_s, 1'b0, 2'd0, '0, 1'b1, 1'b0, 2'd1);
    idle(2'd1); chk("R7 ack while idle ignored", int'(o_rd), 'h10);
    step(cur_s, 1'b0, 2'd0, '0, 1'b0, 1'b1, 2'd0);
    idle(2'd0); chk("R8 reti restores, next pending", int'(o_vec), 'h10A);
    step(cur_s, 1'b1, 2'd2, 6'h01, 1'b1, 1'b1, 2'd0);
    idle(2'd2); chk("R8 ack beats reti and write", int'(o_rd), 0);

    wr(2'd2, 6'h01);
    step(6'b000000, 1'b0, 2'd0, '0, 1'b0, 1'b0, 2'd0);
    step(6'b000001, 1'b0, 2'd0, '0, 1'b0, 1'b0, 2'd0);
    step(6'b000001, 1'b1, 2'd1, 6'h3E, 1'b0, 1'b0, 2'd0);
    idle(2'd1); chk("R3 write of zero keeps flag", int'(o_rd), 'h01);
    step(6'b000000, 1'b0, 2'd0, '0, 1'b0, 1'b0, 2'd0);
    step(6'b000001, 1'b1, 2'd1, 6'h01, 1'b0, 1'b0, 2'd0);
    idle(2'd1); chk("R3 set wins over clear", int'(o_rd), 'h01);
    wr(2'd1, 6'h01);
    idle(2'd1); chk("R3 write one clears", int'(o_rd), 'h00);

    wr(2'd0, 6'h00);
    step(6'b000100, 1'b0, 2'd0, '0, 1'b0, 1'b0, 2'd0);
    step(6'b000000, 1'b0, 2'd0, '0, 1'b0, 1'b0, 2'd0);
    wr(2'd0, 6'h3F);
    idle(2'd3); chk("R4 vanished level leaves nothing", int'(o_rd), 0);
    chk("R4 no irq", int'(o_irq), 0);
    step(6'b000100, 1'b0, 2'd0, '0, 1'b0, 1'b0, 2'd1);
    chk("R4 level requests while high", int'(o_vec), 'h106);
    chk("R4 level has no flag", int'(o_rd), 0);
    step(6'b000100, 1'b0, 2'd0, '0, 1'b1, 1'b0, 2'd0);
    idle(2'd2); chk("R7 ack on level drops gie", int'(o_rd), 0);
    step(6'b000000, 1'b1, 2'd3, 6'h00, 1'b0, 1'b0, 2'd3);
    idle(2'd0); chk("R9 write to addr3 ignored", int'(o_rd), 'h3F);

    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] s = N'($urandom);
      logic w = ($urandom % 6) == 0;
      logic [1:0] a = 2'($urandom);
      logic [N-1:0] d = N'($urandom);
      logic k = ($urandom % 3) == 0;
      logic r = ($urandom % 5) == 0;
      step(s, w, a, d, k, r, 2'($urandom));
    end

    done = 1;
    summary();
  end
endmodule